// File: doc/BRIEF.md
# Radix-4 Recoded Multiplier with Four-Row Compression Tree

This block forms the full-width product of two W-bit integers in a single combinational pass. The operands are treated as two's complement or as unsigned numbers, as a parameter selects. The work is split into three stages:

- The multiplier operand is recoded into radix-4 signed digits. Each digit selects a shifted, possibly negated copy of the multiplicand, so the row count is about half the operand width.
- The rows are compressed four at a time by 4:2 counters. Each counter passes a lateral carry into the next column. A 3:2 counter row takes care of three leftover rows.
- A carry-propagate addition merges the final pair of rows into the 2W-bit product.

Negative digits are formed as the ones' complement of the magnitude. The missing +1 for each such digit is collected into one extra correction row, which enters the tree with the partial products. In the default signed 24-bit configuration there are twelve digit rows. The block sits inside a datapath wherever a product is needed in the same cycle as its operands.

Top module: `booth_tree_mul`

## Requirements
- R1: With SIGNED=1, `prod` equals the two's complement product of `mul_a` and `mul_b`, in 2W bits.
- R2: With SIGNED=0, `prod` equals the unsigned product of `mul_a` and `mul_b`, in 2W bits.
- R3: Digit i is recoded from the multiplier bits at positions 2i+1, 2i and 2i-1, with bit -1 read as 0 and positions above W-1 filled with the sign bit (SIGNED=1) or with 0 (SIGNED=0). Its value is -2*b[2i+1] + b[2i] + b[2i-1]. The digits, weighted by 4^i, sum to the multiplier's value.
- R4: Each digit selects at most one magnitude, either 1x or 2x the multiplicand. A negation is applied only with a nonzero magnitude, so the triplets 000 and 111 give a zero row with no correction.
- R5: The two rows that leave the compression tree add, modulo 2^(2W), to `prod`.
- R6: At the corners the product is exact: a zero operand gives 0, and the most negative value squared gives 2^(2W-2). With SIGNED=0, all-ones times all-ones gives (2^W-1)^2.
- R7: The block holds no state. `prod` follows an operand change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_a | input | W | Multiplicand |
| mul_b | input | W | Multiplier, recoded into radix-4 digits |
| prod | output | 2W | Full-width product |

## Verification
The bound checker re-derives the following on every input change, from the block's own internal boundaries:
- the product against an arithmetic multiply;
- the digit set against the multiplier value;
- the one-magnitude rule for every digit;
- the sum of the two rows that leave the tree.

Only the bench's scenarios can show two things. The first is that every operand pair of a small 6-bit configuration, in both signed and unsigned forms, gives the right product. The second is that the named corners, and an operand change with no clock edge in between, behave as required at the ports.

// File: rtl/booth_mul_pkg.sv
`timescale 1ns/1ps
package booth_mul_pkg;

   // Number of radix-4 digits needed to cover a w-bit multiplier.
   function automatic int digit_count(input int w, input bit sgn);
      return sgn ? (w + 1) / 2 : (w / 2) + 1;
   endfunction

   // Rows left after one compression level: fours become twos,
   // three leftovers become two, one or two leftovers pass through.
   function automatic int next_rows(input int r);
      if (r <= 2) return r;
      return 2 * (r / 4) + (((r % 4) == 3) ? 2 : (r % 4));
   endfunction

   function automatic int rows_at(input int r0, input int lvl);
      int r = r0;
      for (int k = 0; k < lvl; k++) r = next_rows(r);
      return r;
   endfunction

   function automatic int tree_levels(input int r0);
      int r = r0;
      int n = 0;
      while (r > 2) begin
         r = next_rows(r);
         n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/booth_pp_row.sv
`timescale 1ns/1ps
module booth_pp_row #(
   parameter int W     = 24,
   parameter int PW    = 48,
   parameter int SHIFT = 0
) (
   input  logic [W:0]    a_ext,
   input  logic [2:0]    trip,
   output logic [PW-1:0] row,
   output logic          is_one,
   output logic          is_two,
   output logic          is_neg
);
   localparam int MW = W + 2;

   logic [MW-1:0] mag;
   logic [MW-1:0] sel;
   logic [PW-1:0] ext;

   assign is_one = trip[0] ^ trip[1];
   assign is_two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
   assign is_neg = trip[2] & ~(trip[1] & trip[0]);

   always_comb begin
      if (is_one)      mag = {a_ext[W], a_ext};
      else if (is_two) mag = {a_ext, 1'b0};
      else             mag = '0;
      sel = is_neg ? ~mag : mag;
      ext = {{(PW - MW){sel[MW-1]}}, sel};
      row = ext << SHIFT;
   end
endmodule

// File: rtl/csa32_row.sv
`timescale 1ns/1ps
module csa32_row #(
   parameter int PW = 48
) (
   input  logic [PW-1:0] in0,
   input  logic [PW-1:0] in1,
   input  logic [PW-1:0] in2,
   output logic [PW-1:0] sum,
   output logic [PW-1:0] carry
);
   logic [PW-2:0] maj;

   assign sum = in0 ^ in1 ^ in2;
   assign maj = (in0[PW-2:0] & in1[PW-2:0]) | (in0[PW-2:0] & in2[PW-2:0])
              | (in1[PW-2:0] & in2[PW-2:0]);
   assign carry = {maj, 1'b0};
endmodule

// File: rtl/csa42_row.sv
`timescale 1ns/1ps
module csa42_row #(
   parameter int PW = 48
) (
   input  logic [PW-1:0] in0,
   input  logic [PW-1:0] in1,
   input  logic [PW-1:0] in2,
   input  logic [PW-1:0] in3,
   output logic [PW-1:0] sum,
   output logic [PW-1:0] carry
);
   logic [PW-2:0] lat;
   logic [PW-2:0] cy;

   for (genvar j = 0; j < PW; j++) begin : g_col
      logic cin;
      logic s1;
      if (j == 0) begin : g_lsb
         assign cin = 1'b0;
      end else begin : g_mid
         assign cin = lat[j-1];
      end
      assign s1     = in0[j] ^ in1[j] ^ in2[j];
      assign sum[j] = s1 ^ in3[j] ^ cin;
      if (j < PW - 1) begin : g_cy
         assign lat[j] = (in0[j] & in1[j]) | (in0[j] & in2[j]) | (in1[j] & in2[j]);
         assign cy[j]  = (s1 & in3[j]) | (s1 & cin) | (in3[j] & cin);
      end
   end

   assign carry = {cy, 1'b0};
endmodule

// File: rtl/booth_tree_mul.sv
`timescale 1ns/1ps
module booth_tree_mul #(
   parameter int W      = 24,
   parameter bit SIGNED = 1'b1
) (
   input  logic [W-1:0]   mul_a,
   input  logic [W-1:0]   mul_b,
   output logic [2*W-1:0] prod
);
   localparam int PW   = 2 * W;
   localparam int NPP  = booth_mul_pkg::digit_count(W, SIGNED);
   localparam int R0   = NPP + 1;
   localparam int NLVL = booth_mul_pkg::tree_levels(R0);

   if (W < 4) begin : g_bad_width
      $error("booth_tree_mul: W must be at least 4");
   end

   logic [W:0]      a_ext;
   logic [2*NPP:0]  b_ext;
   logic [PW-1:0]   pp_row [NPP];
   logic [PW-1:0]   corr;
   logic [NPP-1:0]  dig_one;
   logic [NPP-1:0]  dig_two;
   logic [NPP-1:0]  dig_neg;
   logic [PW-1:0]   fin_s;
   logic [PW-1:0]   fin_c;

   assign a_ext = {(SIGNED ? mul_a[W-1] : 1'b0), mul_a};

   always_comb begin
      b_ext = '0;
      b_ext[W:1] = mul_b;
      for (int k = W + 1; k <= 2 * NPP; k++) b_ext[k] = SIGNED ? mul_b[W-1] : 1'b0;
   end

   // Stage 1: digit recoding and row selection
   for (genvar i = 0; i < NPP; i++) begin : g_dig
      booth_pp_row #(.W(W), .PW(PW), .SHIFT(2 * i)) i_row (
         .a_ext (a_ext),
         .trip  (b_ext[2*i+2 -: 3]),
         .row   (pp_row[i]),
         .is_one(dig_one[i]),
         .is_two(dig_two[i]),
         .is_neg(dig_neg[i])
      );
   end

   always_comb begin
      corr = '0;
      for (int i = 0; i < NPP; i++) corr[2*i] = dig_neg[i];
   end

   // Stage 2: compression, four rows at a time
   for (genvar l = 0; l <= NLVL; l++) begin : g_lvl
      localparam int NR = booth_mul_pkg::rows_at(R0, l);
      logic [PW-1:0] rw [NR];
      if (l == 0) begin : g_src
         for (genvar k = 0; k < NPP; k++) begin : g_pp
            assign rw[k] = pp_row[k];
         end
         assign rw[NPP] = corr;
      end else begin : g_red
         localparam int PR = booth_mul_pkg::rows_at(R0, l - 1);
         localparam int NG = PR / 4;
         localparam int LO = PR % 4;
         for (genvar g = 0; g < NG; g++) begin : g_grp
            csa42_row #(.PW(PW)) i_c42 (
               .in0  (g_lvl[l-1].rw[4*g]),
               .in1  (g_lvl[l-1].rw[4*g+1]),
               .in2  (g_lvl[l-1].rw[4*g+2]),
               .in3  (g_lvl[l-1].rw[4*g+3]),
               .sum  (rw[2*g]),
               .carry(rw[2*g+1])
            );
         end
         if (LO == 3) begin : g_three
            csa32_row #(.PW(PW)) i_c32 (
               .in0  (g_lvl[l-1].rw[4*NG]),
               .in1  (g_lvl[l-1].rw[4*NG+1]),
               .in2  (g_lvl[l-1].rw[4*NG+2]),
               .sum  (rw[2*NG]),
               .carry(rw[2*NG+1])
            );
         end else begin : g_pass
            for (genvar k = 0; k < LO; k++) begin : g_thru
               assign rw[2*NG+k] = g_lvl[l-1].rw[4*NG+k];
            end
         end
      end
   end

   // Stage 3: carry-propagate merge
   assign fin_s = g_lvl[NLVL].rw[0];
   assign fin_c = g_lvl[NLVL].rw[1];
   assign prod  = fin_s + fin_c;

endmodule

// File: rtl/booth_tree_mul_chk.sv
`timescale 1ns/1ps
module booth_tree_mul_chk #(
   parameter int W      = 24,
   parameter bit SIGNED = 1'b1
) (
   input logic [W-1:0]   mul_a,
   input logic [W-1:0]   mul_b,
   input logic [2*W-1:0] prod,
   input logic [booth_mul_pkg::digit_count(W, SIGNED)-1:0] dig_one,
   input logic [booth_mul_pkg::digit_count(W, SIGNED)-1:0] dig_two,
   input logic [booth_mul_pkg::digit_count(W, SIGNED)-1:0] dig_neg,
   input logic [2*W-1:0] fin_s,
   input logic [2*W-1:0] fin_c
);
   localparam int PW  = 2 * W;
   localparam int NPP = booth_mul_pkg::digit_count(W, SIGNED);

   logic [PW-1:0]          ea, eb;
   logic signed [PW+1:0]   bval, acc;

   always_comb begin
      if (SIGNED) begin
         ea   = PW'(signed'(mul_a));
         eb   = PW'(signed'(mul_b));
         bval = (PW+2)'(signed'(mul_b));
      end else begin
         ea   = PW'(mul_a);
         eb   = PW'(mul_b);
         bval = (PW+2)'(mul_b);
      end
      acc = '0;
      for (int i = 0; i < NPP; i++) begin
         logic signed [PW+1:0] dv;
         dv = dig_two[i] ? (PW+2)'(2) : (dig_one[i] ? (PW+2)'(1) : '0);
         if (dig_neg[i]) dv = -dv;
         acc = acc + (dv <<< (2 * i));
      end
   end

   always_comb begin
      if (SIGNED) begin
         p_signed_product_r1: assert (prod == PW'(ea * eb));
      end else begin
         p_unsigned_product_r2: assert (prod == PW'(ea * eb));
      end
      p_digit_sum_r3: assert (acc == bval);
      for (int i = 0; i < NPP; i++) begin
         p_one_magnitude_r4: assert ($onehot0({dig_one[i], dig_two[i]}));
         p_neg_nonzero_r4: assert (!dig_neg[i] || dig_one[i] || dig_two[i]);
      end
      p_final_rows_r5: assert (PW'(fin_s + fin_c) == prod);
   end
endmodule

bind booth_tree_mul booth_tree_mul_chk #(.W(W), .SIGNED(SIGNED)) i_chk (
   .mul_a  (mul_a),
   .mul_b  (mul_b),
   .prod   (prod),
   .dig_one(dig_one),
   .dig_two(dig_two),
   .dig_neg(dig_neg),
   .fin_s  (fin_s),
   .fin_c  (fin_c)
);

// File: tb/test_booth_tree_mul.sv
`timescale 1ns/1ps
module test_booth_tree_mul;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   logic [23:0] a24, b24;
   logic [47:0] p24;
   logic [5:0]  a6, b6;
   logic [11:0] ps6, pu6;

   booth_tree_mul i_booth_tree_mul (.mul_a(a24), .mul_b(b24), .prod(p24));
   booth_tree_mul #(.W(6), .SIGNED(1'b1)) i_booth_tree_mul_s6 (.mul_a(a6), .mul_b(b6), .prod(ps6));
   booth_tree_mul #(.W(6), .SIGNED(1'b0)) i_booth_tree_mul_u6 (.mul_a(a6), .mul_b(b6), .prod(pu6));

   task automatic check(input logic [47:0] act, input logic [47:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [47:0] sprod24(input logic [23:0] a, input logic [23:0] b);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      return 48'(sa * sb);
   endfunction

   task automatic apply24(input logic [23:0] a, input logic [23:0] b, input string tag);
      @(posedge clk);
      a24 = a;
      b24 = b;
      @(negedge clk);
      check(p24, sprod24(a, b), tag);
   endtask

   initial begin
      a24 = '0; b24 = '0; a6 = '0; b6 = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Zero operands after reset give a zero product (R6)
      check(p24, 48'd0, "R6 zero after reset");
      check({36'd0, ps6}, 48'd0, "R6 zero after reset s6");

      // Exhaustive sweep of the 6-bit configurations
      for (int i = 0; i < 64; i++) begin
         for (int j = 0; j < 64; j++) begin
            @(posedge clk);
            a6 = 6'(i);
            b6 = 6'(j);
            @(negedge clk);
            check({36'd0, ps6}, {36'd0, 12'(int'($signed(6'(i))) * int'($signed(6'(j))))}, "R1 signed sweep");
            check({36'd0, pu6}, {36'd0, 12'(i * j)}, "R2 unsigned sweep");
         end
      end

      // R3: multiplicand 1 returns the multiplier through the digit set
      for (int k = 0; k < 200; k++) begin
         logic [23:0] rb;
         rb = 24'($urandom);
         apply24(24'd1, rb, "R3 unit multiplicand");
      end

      // R4: triplets 000 and 111 everywhere
      apply24(24'h5a5a5a, 24'h000000, "R4 all-zero triplets");
      apply24(24'h5a5a5a, 24'hffffff, "R4 all-one triplets");
      apply24(24'h123456, 24'hfffff0, "R4 mixed triplets");

      // R6: corners
      apply24(24'h800000, 24'h800000, "R6 most negative squared");
      apply24(24'h800000, 24'h7fffff, "R6 min times max");
      apply24(24'h7fffff, 24'h7fffff, "R6 max squared");
      apply24(24'hffffff, 24'hffffff, "R6 minus one squared");
      apply24(24'h000000, 24'h800000, "R6 zero multiplicand");
      @(posedge clk);
      a6 = 6'h3f; b6 = 6'h3f;
      @(negedge clk);
      check({36'd0, pu6}, {36'd0, 12'd3969}, "R6 unsigned all-ones");
      check({36'd0, ps6}, {36'd0, 12'd1}, "R6 signed all-ones");

      // R1 R5: random 24-bit operands
      for (int k = 0; k < 3000; k++) begin
         apply24(24'($urandom), 24'($urandom), "R1 R5 random");
      end

      // R7: operand change with no clock edge in between
      @(negedge clk);
      a24 = 24'h000123;
      b24 = 24'hfffe00;
      #1;
      check(p24, sprod24(24'h000123, 24'hfffe00), "R7 no clock edge");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule